// File: doc/BRIEF.md
# Locality Access Arbiter

This block decides which of several software contexts, called localities, may drive a memory-mapped security device at any moment. Each locality sees the device through its own 4 KiB address window. Each window has a one-byte access register at offset zero. Software places a claim by writing that register and gives up ownership by writing it again. The arbiter holds exactly one owner at a time. It tells the owner when other localities are waiting, and it raises a one-cycle event whenever ownership is granted or given up.

The arbiter also guards the status and data registers that sit behind it. Only the owning window can read or write them. A window that does not own the device reads all ones there, and its writes are not passed on to the device core. Until the core reports that its self test and initialization are complete, the access register reads as zero and every access write is ignored.

Top module: `locality_arbiter`

## Requirements
- R1: Five localities, 0 to 4, are selected by address bits 14:12, so their windows are 0x1000 bytes apart. An address whose index is 5 or more reads 0xFF, and writes to it are ignored.
- R2: The access register is at window offset 0x000. Bit 7 is valid, bit 5 is owner, bit 2 is others-waiting and bit 1 is own-claim-outstanding. All other bits read 0. The register is read combinationally.
- R3: Valid reads 0 and the whole access register reads 0x00 from reset until the first clock edge at which init_done is 1. From then on valid reads 1, even if init_done falls again. Access writes made before valid is set have no effect.
- R4: Writing an access register with bit 1 set records a claim for that locality. When no locality is active, the pending claim is granted at the next clock edge. The granted locality then reads bit 5 as 1, and at most one locality is ever active.
- R5: Writing bit 5 set to the active locality's access register releases ownership. The same write from any other locality has no effect.
- R6: The active locality reads bit 2 as 1 while any other locality has an outstanding claim.
- R7: loc_change is high for exactly the one cycle that follows each grant edge and each release edge.
- R8: When the device is free and several claims are outstanding, the highest-numbered locality is granted.
- R9: A claim written by the locality that is already active has no effect. It sets no outstanding claim and causes no loc_change.
- R10: Offsets 0x018 to 0x027 hold the status and data registers. In a window that is not active, reads there return 0xFF and core_wr stays low. In the active window, reads return core_rdata and writes assert core_wr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_done | input | 1 | Device core has finished self test and initialization |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| core_rdata | input | 8 | Read data from the device core's registers |
| core_wr | output | 1 | Write forwarded to the device core |
| active_any | output | 1 | Some locality is active |
| active_loc | output | 3 | Index of the active locality |
| loc_change | output | 1 | One-cycle grant/release event for the interrupt logic |

## Verification
On every cycle, the assertions check the following:
- Nothing is held or granted before valid is set.
- A grant picks the highest outstanding claim.
- A release only follows an owner's release write.
- Every change of ownership produces the event pulse.
- core_wr only reaches the device for the owning window.

Other behaviour only the bench's scenarios can show:
- The exact bit images of the access register.
- The all-ones reads through a non-owning window.
- That a claim from the current owner or a release from a bystander leaves the state untouched.
- That valid stays set after init_done drops.

// File: rtl/locality_arbiter.sv
module locality_arbiter #(
  parameter int          NUM_LOC = 5,
  parameter int          ADDR_W  = 16,
  parameter int          IDX_LSB = 12,
  parameter logic [11:0] GATE_LO = 12'h018,
  parameter logic [11:0] GATE_HI = 12'h027
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        core_rdata,
  output logic              core_wr,
  output logic              active_any,
  output logic [2:0]        active_loc,
  output logic              loc_change
);
  localparam int SEL_W = 3;

  logic                 valid_q, active_q, change_q;
  logic [SEL_W-1:0]     act_q, pick;
  logic [NUM_LOC-1:0]   req_q;
  logic                 own_req, others_wait;

  wire [SEL_W-1:0]   sel   = bus_addr[IDX_LSB +: SEL_W];
  wire [IDX_LSB-1:0] ofs   = bus_addr[IDX_LSB-1:0];
  wire sel_ok   = sel < SEL_W'(NUM_LOC);
  wire is_acc   = ofs == '0;
  wire in_gate  = (ofs >= IDX_LSB'(GATE_LO)) && (ofs <= IDX_LSB'(GATE_HI));
  wire owner    = active_q && (act_q == sel);
  wire wr_acc   = bus_wr && is_acc && sel_ok && valid_q;
  wire new_req  = wr_acc && bus_wdata[1] && !owner;
  wire rel      = wr_acc && bus_wdata[5] && owner;
  wire grant    = !active_q && (|req_q);

  always_comb begin
    pick = '0;
    own_req = 1'b0;
    others_wait = 1'b0;
    for (int i = 0; i < NUM_LOC; i++) begin
      if (req_q[i]) pick = SEL_W'(i);
      if (sel == SEL_W'(i)) own_req = req_q[i];
      if (req_q[i] && act_q != SEL_W'(i)) others_wait = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      active_q <= 1'b0;
      act_q    <= '0;
      req_q    <= '0;
      change_q <= 1'b0;
    end else begin
      valid_q  <= valid_q | init_done;
      change_q <= rel | grant;
      for (int i = 0; i < NUM_LOC; i++) begin
        if (new_req && sel == SEL_W'(i)) req_q[i] <= 1'b1;
        if (grant && pick == SEL_W'(i))  req_q[i] <= 1'b0;
      end
      if (rel) begin
        active_q <= 1'b0;
      end else if (grant) begin
        active_q <= 1'b1;
        act_q    <= pick;
      end
    end
  end

  always_comb begin
    if (!sel_ok)      bus_rdata = 8'hFF;
    else if (is_acc)  bus_rdata = {valid_q, 1'b0, owner, 2'b00,
                                   owner && others_wait, own_req, 1'b0};
    else if (in_gate) bus_rdata = owner ? core_rdata : 8'hFF;
    else              bus_rdata = core_rdata;
  end

  assign core_wr    = bus_wr && sel_ok && !is_acc && (!in_gate || owner);
  assign active_any = active_q;
  assign active_loc = act_q;
  assign loc_change = change_q;

  a_r3_nothing_before_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> (!active_q && req_q == '0));

  a_r8_highest_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !$past(active_q)) |-> (($past(req_q) >> act_q) == NUM_LOC'(1)));

  a_r5_release_by_owner: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_q) |-> $past(bus_wr && bus_wdata[5] && is_acc && sel == act_q));

  a_r7_change_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q != $past(active_q)) |-> loc_change);

  a_r10_gate_write: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && in_gate) |-> (active_q && active_loc == sel));

  a_r4_grant_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (act_q < SEL_W'(NUM_LOC)));
endmodule

// File: tb/locality_arbiter_tb.sv
module locality_arbiter_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, init_done = 1'b0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata, core_rdata = 8'h5A;
  logic core_wr, active_any, loc_change;
  logic [2:0] active_loc;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  locality_arbiter dut_i (.clk(clk), .rst_n(rst_n), .init_done(init_done),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .core_rdata(core_rdata), .core_wr(core_wr),
    .active_any(active_any), .active_loc(active_loc), .loc_change(loc_change));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, output logic fwd);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    #1 fwd = core_wr;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string tag);
    bus_addr = a;
    #1 chk(bus_rdata == exp, tag, bus_rdata, exp);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rd_chk(16'h0000, 8'h00, "R3 reset access image");
    chk(!active_any && !loc_change, "R2 reset idle", active_any, 0);
  endtask

  task automatic t_before_valid();
    logic f;
    wr(16'h2000, 8'h02, f);
    step(3);
    chk(!active_any, "R3 claim before valid ignored", active_any, 0);
    rd_chk(16'h2000, 8'h00, "R3 no claim recorded");
  endtask

  task automatic t_valid();
    init_done = 1'b1; step(2); init_done = 1'b0; step(1);
    rd_chk(16'h1000, 8'h80, "R3 valid sticky");
  endtask

  task automatic t_grant();
    logic f;
    wr(16'h2000, 8'h02, f);
    rd_chk(16'h2000, 8'h82, "R2 claim outstanding bit");
    step(1);
    chk(active_any && active_loc == 3'd2, "R4 grant loc2", active_loc, 2);
    chk(loc_change, "R7 pulse on grant", loc_change, 1);
    rd_chk(16'h2000, 8'hA0, "R2 owner image");
    step(1);
    chk(!loc_change, "R7 pulse one cycle", loc_change, 0);
  endtask

  task automatic t_redundant();
    logic f;
    wr(16'h2000, 8'h02, f);
    chk(!loc_change, "R9 no event", loc_change, 0);
    step(1);
    rd_chk(16'h2000, 8'hA0, "R9 owner claim ignored");
  endtask

  task automatic t_foreign_release();
    logic f;
    wr(16'h1000, 8'h20, f);
    step(1);
    chk(active_any && active_loc == 3'd2, "R5 bystander release ignored", active_loc, 2);
    rd_chk(16'h2000, 8'hA0, "R5 owner unchanged");
  endtask

  task automatic t_gate();
    logic f;
    rd_chk(16'h1018, 8'hFF, "R10 non-owner status read");
    rd_chk(16'h2024, 8'h5A, "R10 owner data read");
    wr(16'h1024, 8'h11, f);
    chk(!f, "R10 non-owner write blocked", f, 0);
    wr(16'h2024, 8'h11, f);
    chk(f, "R10 owner write forwarded", f, 1);
  endtask

  task automatic t_range();
    logic f;
    rd_chk(16'h5000, 8'hFF, "R1 index 5 reads FF");
    wr(16'h5000, 8'h02, f);
    step(1);
    rd_chk(16'h2000, 8'hA0, "R1 index 5 write ignored");
  endtask

  task automatic t_priority();
    logic f;
    wr(16'h1000, 8'h02, f);
    wr(16'h4000, 8'h02, f);
    rd_chk(16'h2000, 8'hA4, "R6 others waiting");
    rd_chk(16'h4000, 8'h82, "R1 loc4 claim");
    wr(16'h2000, 8'h20, f);
    chk(!active_any && loc_change, "R5 release and R7 pulse", active_any, 0);
    step(1);
    chk(active_any && active_loc == 3'd4, "R8 highest wins", active_loc, 4);
    wr(16'h4000, 8'h20, f);
    step(1);
    chk(active_any && active_loc == 3'd1, "R4 next claim granted", active_loc, 1);
    rd_chk(16'h1000, 8'hA0, "R6 nobody waiting");
    wr(16'h1000, 8'h20, f);
    step(2);
    chk(!active_any, "R5 idle after release", active_any, 0);
    rd_chk(16'h1000, 8'h80, "R2 idle image");
  endtask

  initial begin
    step(3); rst_n = 1'b1; step(1);
    t_reset();
    t_before_valid();
    t_valid();
    t_grant();
    t_redundant();
    t_foreign_release();
    t_gate();
    t_range();
    t_priority();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule